// File: doc/BRIEF.md
# Tag-Routed Shared Memory Controller

This controller sits between a datapath that produces 32-bit tagged pointers and a set of local block RAMs. Each array owns one RAM. The upper nine bits of a pointer name the RAM, and the lower 23 bits give the element position inside it. A request is decoded in the cycle it arrives. Only the RAM that the tag names receives an enable, an address, a write strobe and write data. Every other RAM sees zeros. The RAMs return read data one cycle later, and an output multiplexer picks the correct lane using a registered copy of the decode.

Two tag values are reserved. The value zero stands for a null pointer. The value one sends the access to an off-chip request/response stub, and the controller then stays busy until that port answers. Local arrays take consecutive tags starting at two. An access is an error if it uses a null pointer, uses a tag that no RAM owns, or uses an index past the RAM depth. An error returns zero and sets a flag that stays set until reset. The number of RAMs, their depth and the data width are parameters.

Top module: `tagmem_ctrl`

## Requirements
- R1: The tag is `req_addr[31:23]` and the index is `req_addr[22:0]`. The index appears unchanged on the address lane of the selected RAM in the cycle the request is accepted, and unselected lanes carry zero address and zero write data.
- R2: Tag 2+k (k < NUM_RAMS) with index < DEPTH raises `ram_en[k]` alone. `ram_we[k]` is raised only when `req_write` is 1, and `req_wdata` is placed on lane k.
- R3: An accepted local load produces `rsp_valid` in the next cycle, with `rsp_rdata` equal to the data that the selected RAM returns in that cycle.
- R4: An accepted local store produces `rsp_valid` in the next cycle, with `rsp_rdata` equal to 0.
- R5: A tag of 0 strobes no RAM. It produces `rsp_valid` in the next cycle with data 0, and `err_flag` goes to 1 from that cycle and stays at 1 until reset.
- R6: A tag above NUM_RAMS+1 behaves exactly as in R5.
- R7: A mapped tag with an index ≥ DEPTH behaves exactly as in R5. Index DEPTH-1 is served normally.
- R8: A tag of 1 raises `busy` and `ext_req_valid` from the next cycle. While they are high, `ext_req_addr` (the full pointer), `ext_req_write` and `ext_req_wdata` are held stable.
- R9: If `ext_rsp_valid` is 1 in a waiting cycle, then in the next cycle `busy` and `ext_req_valid` are 0 and `rsp_valid` is 1. `rsp_rdata` is `ext_rsp_rdata` for a load and 0 for a store.
- R10: While `busy` is 1, requests are ignored. This includes the cycle in which the off-chip answer arrives. An ignored request strobes no RAM, produces no response and does not set the error flag.
- R11: During reset, `rsp_valid`, `busy`, `err_flag` and `ext_req_valid` are 0.
- R12: Requests may be issued in every cycle. Each accepted request gets exactly one response, in issue order, and a store followed immediately by a load of the same element returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Tagged pointer |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | DATA_W | Load result, or zero |
| busy | output | 1 | Off-chip access outstanding |
| err_flag | output | 1 | Sticky bad-access flag |
| ram_en | output | NUM_RAMS | Per-RAM access enable |
| ram_we | output | NUM_RAMS | Per-RAM write strobe |
| ram_addr | output | NUM_RAMS*23 | Per-RAM element address, lane k at bits k*23 |
| ram_wdata | output | NUM_RAMS*DATA_W | Per-RAM write data |
| ram_rdata | input | NUM_RAMS*DATA_W | Per-RAM read data, one cycle after enable |
| ext_req_valid | output | 1 | Off-chip request held |
| ext_req_write | output | 1 | Off-chip request is a store |
| ext_req_addr | output | 32 | Off-chip pointer |
| ext_req_wdata | output | DATA_W | Off-chip store data |
| ext_rsp_valid | input | 1 | Off-chip answer |
| ext_rsp_rdata | input | DATA_W | Off-chip load data |

## Verification
Two things can happen in the same cycle. The output multiplexer can be returning data for the previous request, steered by the registered tag, while a new request strobes a different RAM or the same one. The bench provokes this by issuing requests back to back: a load from one array followed by a store to the other, and a store followed by a load of the same element. A cycle-level model with its own copy of the array contents predicts every response, strobe and lane value. A second overlap arises when a request arrives in the same cycle as the off-chip answer. The model expects that request to be dropped, and a later load of the touched element shows the drop at the ports.

// File: rtl/tagmem_pkg.sv
// Shared constants and types for the tag-routed memory controller.
// Assumes a 32-bit pointer with a 9-bit tag on top of a 23-bit index.
package tagmem_pkg;
    localparam int ADDR_W   = 32;
    localparam int TAG_W    = 9;
    localparam int IDX_W    = 23;
    localparam int TAG_NULL = 0;
    localparam int TAG_EXT  = 1;
    localparam int TAG_BASE = 2;

    // Source that drives the response data in the cycle after acceptance
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_RAM  = 2'd1,
        SRC_ZERO = 2'd2,
        SRC_EXT  = 2'd3
    } rsp_src_e;
endpackage

// File: rtl/tagmem_decode.sv
// Pointer decoder: splits the tag and index, and finds which local RAM
// (if any) owns the tag with the index in range.
// Assumes DEPTH fits in the index field. Purely combinational.
module tagmem_decode
    import tagmem_pkg::*;
#(
    parameter int NUM_RAMS = 2,
    parameter int DEPTH    = 100,
    parameter int SEL_W    = 1
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_RAMS-1:0] hit,
    output logic [SEL_W-1:0]    sel_num,
    output logic [IDX_W-1:0]    idx,
    output logic                is_ext,
    output logic                is_err
);
    localparam logic [IDX_W-1:0] DEPTH_V = IDX_W'(DEPTH);
    localparam logic [TAG_W-1:0] EXT_V   = TAG_W'(TAG_EXT);

    logic [TAG_W-1:0] tag;

    assign tag = addr[ADDR_W-1 -: TAG_W];
    assign idx = addr[IDX_W-1:0];

    // one comparator per RAM: tag match plus range check
    for (genvar k = 0; k < NUM_RAMS; k++) begin : g_hit
        localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(TAG_BASE + k);
        assign hit[k] = (tag == MY_TAG) && (idx < DEPTH_V);
    end

    assign is_ext = (tag == EXT_V);
    assign is_err = !is_ext && (hit == '0);

    // encode the one-hot hit into a lane number for the return multiplexer
    always_comb begin
        sel_num = '0;
        for (int k = 0; k < NUM_RAMS; k++) begin
            if (hit[k]) sel_num = SEL_W'(k);
        end
    end
endmodule

// File: rtl/tagmem_rdmux.sv
// Response data multiplexer: picks one RAM lane, zero, or the captured
// off-chip data, steered by the source and lane registered at acceptance.
// Assumes the RAMs present read data one cycle after enable.
module tagmem_rdmux
    import tagmem_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_RAMS = 2,
    parameter int SEL_W    = 1
) (
    input  logic [NUM_RAMS*DATA_W-1:0] ram_rdata,
    input  rsp_src_e                   src,
    input  logic [SEL_W-1:0]           sel,
    input  logic [DATA_W-1:0]          ext_data,
    output logic [DATA_W-1:0]          rdata
);
    logic [DATA_W-1:0] lane [NUM_RAMS];

    for (genvar k = 0; k < NUM_RAMS; k++) begin : g_lane
        assign lane[k] = ram_rdata[k*DATA_W +: DATA_W];
    end

    // select the response word by registered source
    always_comb begin
        unique case (src)
            SRC_RAM: rdata = lane[sel];
            SRC_EXT: rdata = ext_data;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/tagmem_ext_port.sv
// Off-chip stub port: captures one request and holds it until the far
// side answers, then keeps the answer for one response cycle.
// Assumes the caller only starts when the port is not waiting.
module tagmem_ext_port
    import tagmem_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_write,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_wdata,
    input  logic              ext_rsp_valid,
    input  logic [DATA_W-1:0] ext_rsp_rdata,
    output logic              waiting,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] done_data
);
    assign done = waiting && ext_rsp_valid;

    // hold the request while waiting; capture the answer on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting   <= 1'b0;
            req_write <= 1'b0;
            req_addr  <= '0;
            req_wdata <= '0;
            done_data <= '0;
        end else if (start && !waiting) begin
            waiting   <= 1'b1;
            req_write <= start_write;
            req_addr  <= start_addr;
            req_wdata <= start_wdata;
        end else if (done) begin
            waiting   <= 1'b0;
            done_data <= req_write ? '0 : ext_rsp_rdata;
        end
    end
endmodule

// File: rtl/tagmem_ctrl.sv
// Tag-routed shared memory controller: routes each tagged load or store
// to one local RAM, the off-chip stub, or the error path, and returns
// one response per accepted request.
// Assumes single-cycle synchronous-read RAMs and DEPTH below 2**23.
module tagmem_ctrl
    import tagmem_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_RAMS = 2,
    parameter int DEPTH    = 100
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [31:0]                req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic                       rsp_valid,
    output logic [DATA_W-1:0]          rsp_rdata,
    output logic                       busy,
    output logic                       err_flag,
    output logic [NUM_RAMS-1:0]        ram_en,
    output logic [NUM_RAMS-1:0]        ram_we,
    output logic [NUM_RAMS*23-1:0]     ram_addr,
    output logic [NUM_RAMS*DATA_W-1:0] ram_wdata,
    input  logic [NUM_RAMS*DATA_W-1:0] ram_rdata,
    output logic                       ext_req_valid,
    output logic                       ext_req_write,
    output logic [31:0]                ext_req_addr,
    output logic [DATA_W-1:0]          ext_req_wdata,
    input  logic                       ext_rsp_valid,
    input  logic [DATA_W-1:0]          ext_rsp_rdata
);
    localparam int SEL_W = (NUM_RAMS > 1) ? $clog2(NUM_RAMS) : 1;

    logic [NUM_RAMS-1:0] hit;
    logic [SEL_W-1:0]    sel_num;
    logic [SEL_W-1:0]    sel_q;
    logic [IDX_W-1:0]    idx;
    logic                is_ext;
    logic                is_err;
    logic                accept;
    logic                local_acc;
    logic                ext_wait;
    logic                ext_done;
    logic [DATA_W-1:0]   ext_data;
    rsp_src_e            src_q;

    tagmem_decode #(
        .NUM_RAMS (NUM_RAMS),
        .DEPTH    (DEPTH),
        .SEL_W    (SEL_W)
    ) u_dec (
        .addr    (req_addr),
        .hit     (hit),
        .sel_num (sel_num),
        .idx     (idx),
        .is_ext  (is_ext),
        .is_err  (is_err)
    );

    assign accept    = req_valid && !ext_wait;
    assign local_acc = accept && !is_ext;

    // per-RAM strobes and lanes; idle lanes are held at zero
    for (genvar k = 0; k < NUM_RAMS; k++) begin : g_lane
        assign ram_en[k] = accept && hit[k];
        assign ram_we[k] = accept && hit[k] && req_write;
        assign ram_addr[k*IDX_W +: IDX_W]   = ram_en[k] ? idx : '0;
        assign ram_wdata[k*DATA_W +: DATA_W] = ram_we[k] ? req_wdata : '0;
    end

    tagmem_ext_port #(
        .DATA_W (DATA_W)
    ) u_ext (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (accept && is_ext),
        .start_write   (req_write),
        .start_addr    (req_addr),
        .start_wdata   (req_wdata),
        .ext_rsp_valid (ext_rsp_valid),
        .ext_rsp_rdata (ext_rsp_rdata),
        .waiting       (ext_wait),
        .req_write     (ext_req_write),
        .req_addr      (ext_req_addr),
        .req_wdata     (ext_req_wdata),
        .done          (ext_done),
        .done_data     (ext_data)
    );

    assign busy          = ext_wait;
    assign ext_req_valid = ext_wait;

    // response bookkeeping: valid, data source, lane and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            src_q     <= SRC_NONE;
            sel_q     <= '0;
            err_flag  <= 1'b0;
        end else begin
            rsp_valid <= local_acc || ext_done;
            if (ext_done)
                src_q <= SRC_EXT;
            else if (local_acc)
                src_q <= (is_err || req_write) ? SRC_ZERO : SRC_RAM;
            else
                src_q <= SRC_NONE;
            if (local_acc) sel_q <= sel_num;
            err_flag <= err_flag || (local_acc && is_err);
        end
    end

    tagmem_rdmux #(
        .DATA_W   (DATA_W),
        .NUM_RAMS (NUM_RAMS),
        .SEL_W    (SEL_W)
    ) u_mux (
        .ram_rdata (ram_rdata),
        .src       (src_q),
        .sel       (sel_q),
        .ext_data  (ext_data),
        .rdata     (rsp_rdata)
    );
endmodule

// File: rtl/tagmem_ctrl_chk.sv
// Property checker for tagmem_ctrl, attached by bind. Observes ports only.
module tagmem_ctrl_chk #(
    parameter int DATA_W   = 32,
    parameter int NUM_RAMS = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [31:0]         req_addr,
    input logic                busy,
    input logic                rsp_valid,
    input logic [DATA_W-1:0]   rsp_rdata,
    input logic                err_flag,
    input logic [NUM_RAMS-1:0] ram_en,
    input logic                ext_req_valid,
    input logic [31:0]         ext_req_addr,
    input logic                ext_rsp_valid
);
    AST_ONE_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ram_en)); // R2

    AST_LOAD_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en != '0) |=> rsp_valid); // R3

    AST_NULL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_addr[31:23] == 9'd0) |=> (err_flag && rsp_valid && rsp_rdata == '0)); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag); // R5

    AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req_valid && !ext_rsp_valid) |=> (ext_req_valid && $stable(ext_req_addr))); // R8

    AST_EXT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req_valid && ext_rsp_valid) |=> (!busy && rsp_valid)); // R9

    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ram_en == '0)); // R10
endmodule

bind tagmem_ctrl tagmem_ctrl_chk #(
    .DATA_W   (DATA_W),
    .NUM_RAMS (NUM_RAMS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .busy          (busy),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .err_flag      (err_flag),
    .ram_en        (ram_en),
    .ext_req_valid (ext_req_valid),
    .ext_req_addr  (ext_req_addr),
    .ext_rsp_valid (ext_rsp_valid)
);

// File: tb/sim_tagmem_ctrl.sv
`timescale 1ns/1ps
module sim_tagmem_ctrl;
    localparam int DW = 32;
    localparam int NR = 2;
    localparam int DP = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic rsp_valid, busy, err_flag;
    logic [DW-1:0] rsp_rdata;
    logic [NR-1:0] ram_en, ram_we;
    logic [NR*23-1:0] ram_addr;
    logic [NR*DW-1:0] ram_wdata, ram_rdata;
    logic ext_req_valid, ext_req_write;
    logic [31:0] ext_req_addr;
    logic [DW-1:0] ext_req_wdata;
    logic ext_rsp_valid = 1'b0;
    logic [DW-1:0] ext_rsp_rdata = '0;

    always #4 clk = ~clk;

    tagmem_ctrl #(.DATA_W(DW), .NUM_RAMS(NR), .DEPTH(DP)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .busy(busy), .err_flag(err_flag),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .ext_req_valid(ext_req_valid), .ext_req_write(ext_req_write),
        .ext_req_addr(ext_req_addr), .ext_req_wdata(ext_req_wdata),
        .ext_rsp_valid(ext_rsp_valid), .ext_rsp_rdata(ext_rsp_rdata));

    int checks = 0, errors = 0;
    string cur_req = "R11";
    bit finished = 0;

    // environment RAMs driven only by the DUT strobes (read-before-write)
    logic [DW-1:0] ram_mem [NR][DP];
    logic [DW-1:0] rd_q [NR];
    for (genvar k = 0; k < NR; k++) begin : g_rd
        assign ram_rdata[k*DW +: DW] = rd_q[k];
    end
    always @(posedge clk) begin
        for (int k = 0; k < NR; k++) begin
            automatic int a = int'(ram_addr[k*23 +: 23]);
            if (a < DP) begin
                rd_q[k] <= ram_mem[k][a];
                if (ram_we[k]) ram_mem[k][a] <= ram_wdata[k*DW +: DW];
            end else rd_q[k] <= '0;
        end
    end

    // off-chip stub: answers after ext_lat waiting cycles
    int ext_lat = 1;
    int ext_cnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            ext_rsp_valid = 1'b0; ext_cnt = 0;
        end else if (ext_rsp_valid) begin
            ext_rsp_valid = 1'b0; ext_cnt = 0;
        end else if (ext_req_valid) begin
            ext_cnt++;
            if (ext_cnt >= ext_lat) begin
                ext_rsp_valid = 1'b1;
                ext_rsp_rdata = ext_req_addr ^ 32'h5A5A_0F0F;
            end
        end
    end

    // behavioural reference model with its own copy of the arrays
    logic [DW-1:0] gold [NR][DP];
    bit m_rv = 0, m_busy = 0, m_err = 0, m_ew = 0;
    logic [DW-1:0] m_rd = '0, m_ewd = '0;
    logic [31:0] m_ea = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rv = 0; m_busy = 0; m_err = 0; m_rd = '0;
        end else begin
            m_rv = 0; m_rd = '0;
            if (m_busy) begin
                if (ext_rsp_valid) begin
                    m_busy = 0; m_rv = 1; m_rd = m_ew ? '0 : ext_rsp_rdata;
                end
            end else if (req_valid) begin
                automatic int t = int'(req_addr[31:23]);
                automatic int i = int'(req_addr[22:0]);
                if (t == 1) begin
                    m_busy = 1; m_ea = req_addr; m_ew = req_write; m_ewd = req_wdata;
                end else if (t >= 2 && t < 2 + NR && i < DP) begin
                    m_rv = 1;
                    if (req_write) gold[t-2][i] = req_wdata;
                    else m_rd = gold[t-2][i];
                end else begin
                    m_rv = 1; m_err = 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // registered outputs against the model
    task automatic check_regs();
        chk(rsp_valid == m_rv, cur_req, "rsp_valid", 64'(rsp_valid), 64'(m_rv));
        if (m_rv) chk(rsp_rdata == m_rd, cur_req, "rsp_rdata", 64'(rsp_rdata), 64'(m_rd));
        chk(busy == m_busy, cur_req, "busy", 64'(busy), 64'(m_busy));
        chk(ext_req_valid == m_busy, cur_req, "ext_req_valid", 64'(ext_req_valid), 64'(m_busy));
        chk(err_flag == m_err, cur_req, "err_flag", 64'(err_flag), 64'(m_err));
        if (m_busy) begin
            chk(ext_req_addr == m_ea, "R8", "ext_req_addr", 64'(ext_req_addr), 64'(m_ea));
            chk(ext_req_write == m_ew, "R8", "ext_req_write", 64'(ext_req_write), 64'(m_ew));
            chk(ext_req_wdata == m_ewd, "R8", "ext_req_wdata", 64'(ext_req_wdata), 64'(m_ewd));
        end
    endtask

    // strobes and lanes for the request now on the inputs
    task automatic check_comb();
        logic [NR-1:0] xe = '0, xw = '0;
        automatic int t = int'(req_addr[31:23]);
        automatic int i = int'(req_addr[22:0]);
        for (int k = 0; k < NR; k++)
            if (rst_n && req_valid && !m_busy && t == 2 + k && i < DP) begin
                xe[k] = 1'b1; xw[k] = req_write;
            end
        chk(ram_en == xe, cur_req, "ram_en", 64'(ram_en), 64'(xe));
        chk(ram_we == xw, cur_req, "ram_we", 64'(ram_we), 64'(xw));
        for (int k = 0; k < NR; k++) begin
            logic [22:0] xa = xe[k] ? req_addr[22:0] : 23'd0;
            logic [DW-1:0] xd = xw[k] ? req_wdata : '0;
            chk(ram_addr[k*23 +: 23] == xa, "R1", "ram_addr", 64'(ram_addr[k*23 +: 23]), 64'(xa));
            chk(ram_wdata[k*DW +: DW] == xd, "R1", "ram_wdata", 64'(ram_wdata[k*DW +: DW]), 64'(xd));
        end
    endtask

    task automatic cycle(input bit v, input bit w, input logic [31:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        check_regs();
        req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        #1 check_comb();
    endtask

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) cycle(0, 0, 32'd0, '0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0;
        idle(2);
        @(negedge clk);
        chk(!rsp_valid && !busy && !err_flag && !ext_req_valid, "R11", "reset outputs",
            64'({rsp_valid, busy, err_flag, ext_req_valid}), 64'd0);
        rst_n = 1'b1;
    endtask

    function automatic logic [31:0] ptr(input int tag, input int idx);
        return {tag[8:0], idx[22:0]};
    endfunction

    initial begin
        for (int k = 0; k < NR; k++)
            for (int i = 0; i < DP; i++) begin
                ram_mem[k][i] = DW'(32'h1000_0000 * (k + 1) + i);
                gold[k][i]    = DW'(32'h1000_0000 * (k + 1) + i);
            end
        cur_req = "R11";
        do_reset();

        cur_req = "R3";                       // loads from both arrays, last index
        cycle(1, 0, ptr(2, 5), '0);
        cycle(1, 0, ptr(3, 99), '0);
        cycle(1, 0, ptr(2, 0), '0);
        idle(2);

        cur_req = "R4";                       // store then load back (R12)
        cycle(1, 1, ptr(2, 7), 32'hCAFE_0007);
        cur_req = "R12";
        cycle(1, 0, ptr(2, 7), '0);
        cycle(1, 0, ptr(3, 3), '0);           // load B then store A in same response cycle
        cycle(1, 1, ptr(2, 3), 32'hBEEF_0003);
        cycle(1, 1, ptr(3, 3), 32'h1234_5678);
        cycle(1, 0, ptr(3, 3), '0);
        cycle(1, 0, ptr(2, 3), '0);
        idle(2);

        cur_req = "R5";                       // null pointer load and store
        cycle(1, 0, ptr(0, 4), '0);
        cycle(1, 1, ptr(0, 9), 32'hFFFF_FFFF);
        cycle(1, 0, ptr(2, 9), '0);
        idle(3);
        do_reset();

        cur_req = "R6";                       // unmapped tags
        cycle(1, 0, ptr(4, 1), '0);
        cycle(1, 1, ptr(511, 1), 32'h0BAD_0BAD);
        idle(2);
        do_reset();

        cur_req = "R7";                       // last valid index, then first bad one
        cycle(1, 0, ptr(3, 99), '0);
        idle(2);
        cycle(1, 1, ptr(2, 100), 32'h0BAD_0100);
        cycle(1, 0, ptr(3, 100), '0);
        idle(2);
        do_reset();

        cur_req = "R8";                       // off-chip load, latency 1
        ext_lat = 1;
        cycle(1, 0, ptr(1, 42), '0);
        cur_req = "R10";
        cycle(1, 1, ptr(2, 0), 32'hDEAD_0000);
        cur_req = "R9";
        cycle(1, 0, ptr(2, 0), '0);
        idle(2);

        cur_req = "R8";                       // off-chip store, latency 3
        ext_lat = 3;
        cycle(1, 1, ptr(1, 77), 32'h7777_7777);
        cur_req = "R10";
        for (int j = 0; j < 3; j++) cycle(1, 1, ptr(3, 1), 32'hDEAD_0001);
        cur_req = "R9";
        cycle(1, 0, ptr(3, 1), '0);
        cycle(1, 0, ptr(0, 0), '0);
        idle(2);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule